// File: doc/BRIEF.md
# Free-Running Timer with Coherent Byte Readback

This block is a 16-bit up-counter that runs freely from the bus clock through a fixed divide-by-four prescaler. A full lap of the count takes 262,144 bus clocks. Wrapping from the top value back to zero sets an overflow flag. That flag drives an interrupt request when software has enabled it. Software cannot load the count, and reset starts it at 0xFFFC.

The count is read over an 8-bit register bus. Two byte pairs return it: a main pair and an alternate pair. A read of either high byte snapshots the low byte, so the next low-byte read returns a value that matches the high byte already taken. Only the main pair takes part in clearing the overflow flag. Software clears the flag by reading the status register while the flag is set, then reading the main high byte. The alternate pair lets software sample time without disturbing an overflow that is still pending.

Register addresses: 0 control, 1 status, 2 main high, 3 main low, 4 alternate high, 5 alternate low. Addresses 6 and 7 are unused. Read data is combinational and is valid in the same cycle as the read strobe. Side effects of a read take hold at the clock edge that ends that cycle.

Top module: `frt_timer`

## Requirements
- R1: After reset the count is 0xFFFC, the prescaler phase is zero, and both the overflow flag and the interrupt enable are 0. The first increment happens on the fourth clock edge after reset is released.
- R2: The count goes up by exactly one every four clocks. Reads do not change it, and writes to any counter address are ignored.
- R3: When the count wraps from 0xFFFF to 0x0000, the overflow flag sets. The flag is read as bit 7 of the status register (address 1), and the other status bits read 0.
- R4: Bit 0 of the control register (address 0) is a read/write interrupt enable, and the other control bits read 0. `irq` is high exactly when the overflow flag and the enable are both 1.
- R5: A read of the main high byte (address 2) or the alternate high byte (address 4) returns bits 15:8 of the current count.
- R6: A low-byte read (address 3 or 5) with no high-byte read pending returns bits 7:0 of the current count.
- R7: A high-byte read captures bits 7:0 of the count into a snapshot, unless a capture is already pending. Later high-byte reads do not refresh the snapshot. The next low-byte read returns the snapshot and ends the pending state.
- R8: The overflow flag clears on a read of the main high byte, but only if a status read that saw the flag set came first. A wrap that occurs after that status read, or in the same cycle as the main high-byte read, leaves the flag set.
- R9: Reads of the alternate pair (addresses 4 and 5) never change the overflow flag.
- R10: Addresses 6 and 7 read 0. Writes to any address other than 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr and rd_en |
| irq | output | 1 | Overflow interrupt request |

## Verification
The properties assume that at most one of `rd_en` and `wr_en` is high in any cycle. They also assume that each strobe lasts one clock, so a held strobe counts as one read per cycle, and that the address is stable across the edge that samples it. The stimulus changes inputs only on the falling clock edge and issues one access per call. A call raises one strobe for a single cycle and then drops it, so back-to-back reads of the same address appear as distinct accesses. A second instance with a shorter prescaler is driven from the same bus. This lets the flag race, in which a wrap lands between the arming status read and the clearing read, happen within the run.

// File: rtl/frt_pkg.sv
package frt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;

    localparam int TOIE_BIT = 0;
    localparam int TOF_BIT  = 7;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_STAT = 3'd1,
        A_MHI  = 3'd2,
        A_MLO  = 3'd3,
        A_AHI  = 3'd4,
        A_ALO  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cnt_t;

    typedef struct packed {
        logic ctrl;
        logic stat;
        logic mhi;
        logic mlo;
        logic ahi;
        logic alo;
    } rd_sel_t;

    function automatic rd_sel_t decode_rd(input logic en, input logic [ADDR_W-1:0] a);
        rd_sel_t s;
        s.ctrl = en && (a == A_CTRL);
        s.stat = en && (a == A_STAT);
        s.mhi  = en && (a == A_MHI);
        s.mlo  = en && (a == A_MLO);
        s.ahi  = en && (a == A_AHI);
        s.alo  = en && (a == A_ALO);
        return s;
    endfunction

endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] ph_q;

    assign tick = (ph_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)       ph_q <= '0;
        else if (tick) ph_q <= '0;
        else           ph_q <= ph_q + 1'b1;
    end
endmodule

// File: rtl/frt_counter.sv
module frt_counter
    import frt_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output cnt_t cnt_q,
    output logic wrap
);
    assign wrap = tick && (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= cnt_t'(RST_VAL);
        else if (tick) cnt_q <= cnt_t'(cnt_q + CNT_W'(1));
    end
endmodule

// File: rtl/frt_rdbuf.sv
module frt_rdbuf
    import frt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_rd,
    input  logic              lo_rd,
    input  logic [BYTE_W-1:0] live_lo,
    output logic              hold_q,
    output logic [BYTE_W-1:0] snap_q,
    output logic [BYTE_W-1:0] lo_val
);
    assign lo_val = hold_q ? snap_q : live_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            snap_q <= '0;
        end else if (hi_rd && !hold_q) begin
            hold_q <= 1'b1;
            snap_q <= live_lo;
        end else if (lo_rd) begin
            hold_q <= 1'b0;
        end
    end
endmodule

// File: rtl/frt_ovf_flag.sv
module frt_ovf_flag (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic stat_rd,
    input  logic clr_rd,
    output logic tof_q
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tof_q   <= 1'b0;
            armed_q <= 1'b0;
        end else if (wrap) begin
            tof_q   <= 1'b1;
            armed_q <= 1'b0;
        end else if (stat_rd) begin
            armed_q <= tof_q;
        end else if (clr_rd && armed_q) begin
            tof_q   <= 1'b0;
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/frt_timer.sv
module frt_timer
    import frt_pkg::*;
#(
    parameter int               PRESCALE = 4,
    parameter logic [CNT_W-1:0] RST_VAL  = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq
);
    rd_sel_t           sel;
    logic              tick;
    logic              wrap;
    cnt_t              cnt_q;
    logic              tof_q;
    logic              toie_q;
    logic              hold_q;
    logic [BYTE_W-1:0] snap_q;
    logic [BYTE_W-1:0] lo_val;

    assign sel = decode_rd(rd_en, addr);

    frt_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    frt_counter #(.RST_VAL(RST_VAL)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .cnt_q (cnt_q),
        .wrap  (wrap)
    );

    frt_rdbuf u_buf (
        .clk     (clk),
        .rst     (rst),
        .hi_rd   (sel.mhi || sel.ahi),
        .lo_rd   (sel.mlo || sel.alo),
        .live_lo (cnt_q.lo),
        .hold_q  (hold_q),
        .snap_q  (snap_q),
        .lo_val  (lo_val)
    );

    frt_ovf_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .wrap    (wrap),
        .stat_rd (sel.stat),
        .clr_rd  (sel.mhi),
        .tof_q   (tof_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                           toie_q <= 1'b0;
        else if (wr_en && addr == A_CTRL)  toie_q <= wdata[TOIE_BIT];
    end

    assign irq = tof_q && toie_q;

    always_comb begin
        rdata = '0;
        if (sel.ctrl)                 rdata[TOIE_BIT] = toie_q;
        if (sel.stat)                 rdata[TOF_BIT]  = tof_q;
        if (sel.mhi || sel.ahi)       rdata           = cnt_q.hi;
        if (sel.mlo || sel.alo)       rdata           = lo_val;
    end
endmodule

// File: rtl/frt_timer_chk.sv
module frt_timer_chk
    import frt_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  cnt,
    input logic              tick,
    input logic              tof,
    input logic              hold,
    input logic [BYTE_W-1:0] snap
);
    // R1
    reset_value_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> cnt == RST_VAL);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    // R3
    flag_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tof) |-> $past(cnt) == '1);

    // R8
    flag_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tof) |-> $past(rd_en && addr == A_MHI));

    // R9
    alt_keeps_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (tof && rd_en && (addr == A_AHI || addr == A_ALO)) |=> tof);

    // R7
    snap_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && rd_en && (addr == A_MHI || addr == A_AHI)) |=> $stable(snap));

    // R7
    lo_release_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == A_MLO || addr == A_ALO)) |=> !hold);
endmodule

bind frt_timer frt_timer_chk #(.RST_VAL(RST_VAL)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .addr  (addr),
    .cnt   (cnt_q),
    .tick  (tick),
    .tof   (tof_q),
    .hold  (hold_q),
    .snap  (snap_q)
);

// File: tb/frt_timer_tb.sv
module frt_timer_tb_top;
    import frt_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, rdata_f;
    logic       irq, irq_f;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    frt_timer dut_i (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    frt_timer #(.PRESCALE(2)) fast_i (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata_f), .irq(irq_f)
    );

    // reference state of dut_i, from the requirements
    logic [15:0] m_cnt;
    logic [1:0]  m_pre;
    logic        m_tof, m_arm, m_hold, m_toie;
    logic [7:0]  m_snap;
    logic        m_roll;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 16'hFFFC; m_pre <= 2'd0; m_tof <= 1'b0; m_arm <= 1'b0;
            m_hold <= 1'b0; m_snap <= 8'h00; m_toie <= 1'b0;
        end else begin
            m_roll = (m_pre == 2'd3) && (m_cnt == 16'hFFFF);
            m_pre <= m_pre + 2'd1;
            if (m_pre == 2'd3) m_cnt <= m_cnt + 16'd1;
            if (wr_en && addr == 3'd0) m_toie <= wdata[0];
            if (rd_en && (addr == 3'd2 || addr == 3'd4) && !m_hold) begin
                m_hold <= 1'b1; m_snap <= m_cnt[7:0];
            end else if (rd_en && (addr == 3'd3 || addr == 3'd5)) begin
                m_hold <= 1'b0;
            end
            if (m_roll) begin
                m_tof <= 1'b1; m_arm <= 1'b0;
            end else if (rd_en && addr == 3'd1) begin
                m_arm <= m_tof;
            end else if (rd_en && addr == 3'd2 && m_arm) begin
                m_tof <= 1'b0; m_arm <= 1'b0;
            end
        end
    end

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0:       return {7'd0, m_toie};
            3'd1:       return {m_tof, 7'd0};
            3'd2, 3'd4: return m_cnt[15:8];
            3'd3, 3'd5: return m_hold ? m_snap : m_cnt[7:0];
            default:    return 8'h00;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] a);
        case (a)
            3'd0:       return "R4";
            3'd1:       return "R3";
            3'd2, 3'd4: return "R5";
            3'd3, 3'd5: return m_hold ? "R7" : "R6";
            default:    return "R10";
        endcase
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk);
        addr = a; rd_en = 1'b1; wr_en = 1'b0;
        #5;
        chk(rdata, exp_rd(a), req_of(a));
        chk({7'd0, irq}, {7'd0, m_tof & m_toie}, "R4");
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 190000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // R1: reset state straight after release
        @(negedge clk); #5;
        chk(rdata, 8'h00, "R1");
        addr = 3'd2; rd_en = 1'b1; #1;
        chk(rdata, 8'hFF, "R1");
        addr = 3'd3; #1;
        chk(rdata, 8'hFC, "R1");
        addr = 3'd1; #1;
        chk(rdata, 8'h00, "R1");
        chk(rdata_f, 8'h00, "R1");
        rd_en = 1'b0;
        // R1: first advance lands on the fourth edge
        idle(2); #5;
        addr = 3'd3; rd_en = 1'b1; #1;
        chk(rdata, 8'hFC, "R1");
        rd_en = 1'b0;
        @(negedge clk); #5;
        addr = 3'd3; rd_en = 1'b1; #1;
        chk(rdata, 8'hFD, "R1");
        rd_en = 1'b0;

        // R3: wrap sets the flag
        idle(20);
        rd(3'd1);
        chk({7'd0, m_tof}, 8'h01, "R3");
        // R4: enable drives irq
        wr(3'd0, 8'hFF);
        rd(3'd0);
        chk({7'd0, irq}, 8'h01, "R4");
        // R9: alternate reads keep the flag
        rd(3'd1); rd(3'd4); rd(3'd5); rd(3'd5);
        rd(3'd1);
        chk(rdata, 8'h80, "R9");
        // R8: main high read after status clears the flag
        rd(3'd2); rd(3'd3);
        rd(3'd1);
        chk(rdata, 8'h00, "R8");
        chk({7'd0, irq}, 8'h00, "R8");

        // R7: snapshot coherence and no refresh
        rd(3'd2); idle(9);
        rd(3'd4); idle(9);
        rd(3'd3);
        // R6: low read with nothing pending is live
        idle(5);
        rd(3'd5);

        // R2 / R10: writes to other addresses change nothing
        for (int i = 1; i < 8; i++) wr(3'(i), 8'($urandom));
        rd(3'd2); rd(3'd3); rd(3'd0); rd(3'd6); rd(3'd7);

        // mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 6)       rd(3'($urandom % 8));
            else if (op == 6) wr(3'd0, 8'($urandom));
            else if (op == 7) wr(3'(1 + $urandom % 7), 8'($urandom));
            else              idle(int'(1 + $urandom % 3));
        end

        // R8: a wrap between arming and clearing keeps the flag (fast instance)
        do_reset();
        idle(12);
        rd(3'd1);
        chk(rdata_f, 8'h80, "R8");
        idle(131090);
        rd(3'd2);
        rd(3'd1);
        chk(rdata_f, 8'h80, "R8");
        rd(3'd2);
        rd(3'd1);
        chk(rdata_f, 8'h00, "R8");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule